// File: doc/BRIEF.md
# Integer Multiply-Divide Unit with HI/LO Pair

This unit performs 32-bit signed and unsigned multiplication and division and keeps its results in a dedicated HI/LO register pair that sits beside, not inside, the general register file. A single request port carries an operation code and two operands. Besides the four arithmetic operations, the same port carries moves that load HI or LO from an operand, and moves that read HI or LO back onto a registered read-data output.

Division is done by an iterative restoring divider working on magnitudes, with the signs applied to quotient and remainder on the final step. Multiplication is either a shift-and-add loop sharing the divider's accumulator or a single-cycle array, picked by the `MUL_ITER` parameter. While an iterative operation runs, `busy` is high and `reqReady` is low. Every new request, including a read of HI or LO, waits on the port until the result has been written.

Operation codes on `reqOp`: 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 load HI, 5 load LO, 6 read HI, 7 read LO. A request is accepted on a rising clock edge where `reqValid` and `reqReady` are both high.

Top module: `muldiv_hilo`

## Requirements
- R1: Code 0 (signed multiply) writes the full 64-bit two's-complement product of `reqA` and `reqB`: bits 63:32 to HI and bits 31:0 to LO.
- R2: Code 1 (unsigned multiply) writes the 64-bit unsigned product, split between HI and LO in the same way as R1.
- R3: Code 2 (signed divide) writes the quotient, truncated toward zero, to LO and the remainder to HI. The remainder carries the dividend's sign. The case 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R4: Code 3 (unsigned divide) writes the unsigned quotient to LO and the remainder to HI.
- R5: A divide (code 2 or 3) with `reqB` = 0 leaves HI and LO holding their previous values.
- R6: Code 4 loads HI from `reqA` and code 5 loads LO from `reqA`. Codes 6 and 7 return HI and LO respectively on `rdData`, with `rdValid` high in the cycle after acceptance. `rdValid` is high at no other time.
- R7: After a divide is accepted, `busy` is high for exactly 32 cycles (XLEN cycles) and then falls. HI/LO hold the result from the edge on which `busy` falls.
- R8: While `busy` is high, `reqReady` is low. A pending request of any code, whether a read of HI/LO or a new multiply or divide, stays unaccepted until `busy` falls and is taken on the next edge.
- R9: With `MUL_ITER` = 1 a multiply behaves like a divide in timing (R7). With `MUL_ITER` = 0 it writes HI/LO on the accepting edge, and `busy` stays low.
- R10: After reset HI = LO = 0, `busy` = 0, `rdValid` = 0 and `reqReady` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present on the port |
| reqOp | input | 3 | Operation code (see above) |
| reqA | input | XLEN | First operand / dividend / move source |
| reqB | input | XLEN | Second operand / divisor |
| reqReady | output | 1 | Unit can accept a request this cycle |
| busy | output | 1 | Iterative operation in progress |
| rdValid | output | 1 | `rdData` carries a HI or LO read |
| rdData | output | XLEN | Value returned by a read of HI or LO |

## Verification
The hardest situation to reach is a second request arriving in the cycle right after an iterative operation starts, and then staying on the port through the full 32-cycle run. The stimulus for this holds `reqValid` high across the busy window, once with a read of LO and once with a fresh divide. It then counts the busy cycles and confirms that nothing was taken early. The held divide must start on the first edge after release. Sign corner cases rely on operands at zero, minus one and 0x80000000 driven through both the divider and the shift-and-add multiplier. A second instance with the array multiplier covers the zero-latency path.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

  typedef enum logic [2:0] {
    OP_MULS  = 3'd0,
    OP_MULU  = 3'd1,
    OP_DIVS  = 3'd2,
    OP_DIVU  = 3'd3,
    OP_SETHI = 3'd4,
    OP_SETLO = 3'd5,
    OP_GETHI = 3'd6,
    OP_GETLO = 3'd7
  } mdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture operands, start iteration
    logic step;     // one iteration step
    logic finish;   // last step, commit result to HI/LO
    logic fastMul;  // single-cycle multiply commit
    logic setHi;
    logic setLo;
    logic getHi;
    logic getLo;
  } mdCtrl_t;

endpackage

// File: rtl/muldiv_ctrl.sv
`timescale 1ns/1ps
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MUL_ITER = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  output logic       reqReady,
  output logic       busy,
  output logic       rdValid,
  output mdCtrl_t    ctrl
);
  localparam int CNT_W = $clog2(XLEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(XLEN - 1);
  localparam bit ITER_MUL = (MUL_ITER != 0);

  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             rdValidQ;
  logic             accept;
  logic             isMul;
  logic             isDivOp;
  logic             longOp;

  assign accept  = reqValid & ~busyQ;
  assign isMul   = (reqOp[2:1] == 2'b00);
  assign isDivOp = (reqOp[2:1] == 2'b01);
  assign longOp  = isDivOp | (isMul & ITER_MUL);

  always_comb begin
    ctrl         = '0;
    ctrl.load    = accept & longOp;
    ctrl.step    = busyQ;
    ctrl.finish  = busyQ & (cntQ == LAST);
    ctrl.fastMul = accept & isMul & ~ITER_MUL;
    ctrl.setHi   = accept & (mdOp_e'(reqOp) == OP_SETHI);
    ctrl.setLo   = accept & (mdOp_e'(reqOp) == OP_SETLO);
    ctrl.getHi   = accept & (mdOp_e'(reqOp) == OP_GETHI);
    ctrl.getLo   = accept & (mdOp_e'(reqOp) == OP_GETLO);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cntQ     <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= ctrl.getHi | ctrl.getLo;
      if (ctrl.load) begin
        busyQ <= 1'b1;
        cntQ  <= '0;
      end else if (ctrl.finish) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else if (busyQ) begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign reqReady = ~busyQ;
  assign busy     = busyQ;
  assign rdValid  = rdValidQ;

endmodule

// File: rtl/muldiv_dp.sv
`timescale 1ns/1ps
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MUL_ITER = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  mdCtrl_t         ctrl,
  input  logic [2:0]      reqOp,
  input  logic [XLEN-1:0] reqA,
  input  logic [XLEN-1:0] reqB,
  output logic [XLEN-1:0] rdData
);
  localparam int PW = 2 * XLEN;

  logic [XLEN-1:0] hiQ, loQ;
  logic [XLEN-1:0] accHiQ, accLoQ, opBQ;
  logic            isDivQ, negMainQ, negRemQ, zeroDivQ;
  logic [XLEN-1:0] rdDataQ;

  // operand preparation
  logic            sgnOp, aNeg, bNeg;
  logic [XLEN-1:0] absA, absB;

  always_comb begin
    sgnOp = ~reqOp[0];
    aNeg  = sgnOp & reqA[XLEN-1];
    bNeg  = sgnOp & reqB[XLEN-1];
    absA  = aNeg ? (~reqA + 1'b1) : reqA;
    absB  = bNeg ? (~reqB + 1'b1) : reqB;
  end

  // one restoring-divide step
  logic [XLEN:0]   divShift, divDiff;
  logic            divFits;
  logic [XLEN-1:0] divHiN, divLoN;
  // one shift-and-add multiply step
  logic [XLEN:0]   mulSum;
  logic [XLEN-1:0] mulHiN, mulLoN;
  logic [XLEN-1:0] stepHi, stepLo;

  always_comb begin
    divShift = {accHiQ, accLoQ[XLEN-1]};
    divDiff  = divShift - {1'b0, opBQ};
    divFits  = ~divDiff[XLEN];
    divHiN   = divFits ? divDiff[XLEN-1:0] : divShift[XLEN-1:0];
    divLoN   = {accLoQ[XLEN-2:0], divFits};

    mulSum   = {1'b0, accHiQ} + (accLoQ[0] ? {1'b0, opBQ} : {(XLEN+1){1'b0}});
    mulHiN   = mulSum[XLEN:1];
    mulLoN   = {mulSum[0], accLoQ[XLEN-1:1]};

    stepHi   = isDivQ ? divHiN : mulHiN;
    stepLo   = isDivQ ? divLoN : mulLoN;
  end

  // sign fix-up on the final step
  logic [PW-1:0]   prodRaw, prodFix;
  logic [XLEN-1:0] quoFix, remFix, finHi, finLo;
  logic            commitOk;

  always_comb begin
    prodRaw  = {stepHi, stepLo};
    prodFix  = negMainQ ? (~prodRaw + 1'b1) : prodRaw;
    quoFix   = negMainQ ? (~stepLo + 1'b1) : stepLo;
    remFix   = negRemQ ? (~stepHi + 1'b1) : stepHi;
    finHi    = isDivQ ? remFix : prodFix[PW-1:XLEN];
    finLo    = isDivQ ? quoFix : prodFix[XLEN-1:0];
    commitOk = ~(isDivQ & zeroDivQ);
  end

  // single-cycle array multiplier, present only when selected
  logic [PW-1:0] fastProd;
  generate
    if (MUL_ITER == 0) begin : g_array_mul
      logic [PW-1:0] extA, extB;
      assign extA     = {{XLEN{aNeg}}, reqA};
      assign extB     = {{XLEN{bNeg}}, reqB};
      assign fastProd = extA * extB;
    end else begin : g_iter_mul
      assign fastProd = '0;
    end
  endgenerate

  // iteration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accHiQ   <= '0;
      accLoQ   <= '0;
      opBQ     <= '0;
      isDivQ   <= 1'b0;
      negMainQ <= 1'b0;
      negRemQ  <= 1'b0;
      zeroDivQ <= 1'b0;
    end else if (ctrl.load) begin
      accHiQ   <= '0;
      accLoQ   <= absA;
      opBQ     <= absB;
      isDivQ   <= reqOp[1];
      negMainQ <= aNeg ^ bNeg;
      negRemQ  <= aNeg;
      zeroDivQ <= (reqB == '0);
    end else if (ctrl.step) begin
      accHiQ <= stepHi;
      accLoQ <= stepLo;
    end
  end

  // architectural HI/LO and read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ     <= '0;
      loQ     <= '0;
      rdDataQ <= '0;
    end else begin
      if (ctrl.finish && commitOk) begin
        hiQ <= finHi;
        loQ <= finLo;
      end else if (ctrl.fastMul) begin
        hiQ <= fastProd[PW-1:XLEN];
        loQ <= fastProd[XLEN-1:0];
      end else begin
        if (ctrl.setHi) hiQ <= reqA;
        if (ctrl.setLo) loQ <= reqA;
      end
      if (ctrl.getHi)      rdDataQ <= hiQ;
      else if (ctrl.getLo) rdDataQ <= loQ;
    end
  end

  assign rdData = rdDataQ;

endmodule

// File: rtl/muldiv_hilo.sv
`timescale 1ns/1ps
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MUL_ITER = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      reqOp,
  input  logic [XLEN-1:0] reqA,
  input  logic [XLEN-1:0] reqB,
  output logic            reqReady,
  output logic            busy,
  output logic            rdValid,
  output logic [XLEN-1:0] rdData
);
  mdCtrl_t ctrl;

  muldiv_ctrl #(.XLEN(XLEN), .MUL_ITER(MUL_ITER)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqReady(reqReady), .busy(busy), .rdValid(rdValid), .ctrl(ctrl)
  );

  muldiv_dp #(.XLEN(XLEN), .MUL_ITER(MUL_ITER)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqOp(reqOp),
    .reqA(reqA), .reqB(reqB), .rdData(rdData)
  );

endmodule

// File: rtl/muldiv_hilo_chk.sv
`timescale 1ns/1ps
module muldiv_hilo_chk #(
  parameter int XLEN     = 32,
  parameter int MUL_ITER = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [2:0] reqOp,
  input logic       reqReady,
  input logic       busy,
  input logic       rdValid
);
  localparam int RUN_W = $clog2(XLEN) + 2;

  logic [RUN_W-1:0] busyRun;
  logic             taken;

  assign taken = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R8: no acceptance while an operation runs
  p_stall_while_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);

  // R6: an accepted read produces rdValid next cycle
  p_read_returns_r6: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqOp[2:1] == 2'b11) |=> rdValid);

  // R6: rdValid only follows an accepted read
  p_read_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(taken && reqOp[2:1] == 2'b11));

  // R7: an accepted divide raises busy
  p_div_starts_r7: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqOp[2:1] == 2'b01) |=> busy);

  // R7: every busy run lasts exactly XLEN cycles
  p_busy_length_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && busyRun != '0) |-> (busyRun == RUN_W'(XLEN)));

  generate
    if (MUL_ITER == 0) begin : g_fast_chk
      // R9: array multiply never raises busy
      p_fast_mul_r9: assert property (@(posedge clk) disable iff (!rstN)
        (taken && reqOp[2:1] == 2'b00) |=> !busy);
    end else begin : g_iter_chk
      // R9: iterative multiply raises busy
      p_iter_mul_r9: assert property (@(posedge clk) disable iff (!rstN)
        (taken && reqOp[2:1] == 2'b00) |=> busy);
    end
  endgenerate

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.XLEN(XLEN), .MUL_ITER(MUL_ITER)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .reqReady(reqReady), .busy(busy), .rdValid(rdValid)
);

// File: tb/muldiv_hilo_tb_top.sv
`timescale 1ns/1ps
module muldiv_hilo_tb_top;
  localparam int XLEN = 32;
  localparam logic [2:0] MULS = 3'd0, MULU = 3'd1, DIVS = 3'd2, DIVU = 3'd3,
                         SETHI = 3'd4, SETLO = 3'd5, GETHI = 3'd6, GETLO = 3'd7;
  localparam logic [31:0] MINV = 32'h8000_0000, NEG1 = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [31:0] reqA = '0, reqB = '0;
  logic        reqReady, busy, rdValid;
  logic [31:0] rdData;

  logic        fValid = 1'b0;
  logic [2:0]  fOp = '0;
  logic [31:0] fA = '0, fB = '0;
  logic        fReady, fBusy, fRdValid;
  logic [31:0] fRdData;

  muldiv_hilo #(.XLEN(XLEN), .MUL_ITER(1)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqA(reqA),
    .reqB(reqB), .reqReady(reqReady), .busy(busy), .rdValid(rdValid), .rdData(rdData));

  muldiv_hilo #(.XLEN(XLEN), .MUL_ITER(0)) fast_i (
    .clk(clk), .rstN(rstN), .reqValid(fValid), .reqOp(fOp), .reqA(fA),
    .reqB(fB), .reqReady(fReady), .busy(fBusy), .rdValid(fRdValid), .rdData(fRdData));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] mHi = '0, mLo = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference for HI/LO
  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] sp, sa, sb, q, r;
    logic [63:0] up;
    case (op)
      MULS: begin
        sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
        sp = sa * sb; mHi = sp[63:32]; mLo = sp[31:0];
      end
      MULU: begin
        up = {32'b0, a} * {32'b0, b}; mHi = up[63:32]; mLo = up[31:0];
      end
      DIVS: if (b != 0) begin
        sa = {{32{a[31]}}, a}; sb = {{32{b[31]}}, b};
        q = sa / sb; r = sa % sb; mLo = q[31:0]; mHi = r[31:0];
      end
      DIVU: if (b != 0) begin
        mLo = a / b; mHi = a % b;
      end
      SETHI: mHi = a;
      SETLO: mLo = a;
      default: ;
    endcase
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqA = a; reqB = b;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic readBoth(input string req);
    @(negedge clk);
    reqValid = 1'b1; reqOp = GETLO;
    @(posedge clk); @(negedge clk);
    check(rdValid && rdData == mLo, req, "LO read", {31'b0, rdValid, rdData}, {32'h1, mLo});
    reqOp = GETHI;
    @(posedge clk); @(negedge clk);
    check(rdValid && rdData == mHi, req, "HI read", {31'b0, rdValid, rdData}, {32'h1, mHi});
    reqValid = 1'b0;
  endtask

  task automatic shortOp(input logic [2:0] op, input logic [31:0] a);
    model(op, a, '0);
    issue(op, a, '0);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // iterative op with a read of LO held on the port for the whole run
  task automatic longOp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        input string req);
    int cnt;
    bit early;
    model(op, a, b);
    issue(op, a, b);
    @(negedge clk);
    reqOp = GETLO;
    cnt = 0; early = 1'b0;
    while (busy && cnt < 100) begin
      if (reqReady || rdValid) early = 1'b1;
      cnt++;
      @(negedge clk);
    end
    check(cnt == XLEN, "R7", "busy cycles", 64'(cnt), 64'(XLEN));
    check(!early, "R8", "held read taken early", {63'b0, early}, 64'h0);
    @(posedge clk); @(negedge clk);
    check(rdValid && rdData == mLo, req, "LO", {31'b0, rdValid, rdData}, {32'h1, mLo});
    reqOp = GETHI;
    @(posedge clk); @(negedge clk);
    check(rdValid && rdData == mHi, req, "HI", {31'b0, rdValid, rdData}, {32'h1, mHi});
    reqValid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual=running expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0 && reqReady == 1'b1 && rdValid == 1'b0, "R10", "flags",
          {61'b0, busy, reqReady, rdValid}, 64'h2);
    rstN = 1'b1;
    readBoth("R10");

    // R6: moves
    shortOp(SETHI, 32'h1234_5678);
    shortOp(SETLO, 32'h9ABC_DEF0);
    readBoth("R6");

    // R5: divide by zero keeps HI/LO
    longOp(DIVS, 32'd77, 32'd0, "R5");
    longOp(DIVU, NEG1, 32'd0, "R5");

    // R1 / R9: signed multiply, iterative
    longOp(MULS, -32'sd3, 32'd7, "R1");
    longOp(MULS, MINV, MINV, "R1");
    longOp(MULS, MINV, NEG1, "R1");
    longOp(MULS, NEG1, NEG1, "R1");
    longOp(MULS, 32'd0, 32'hDEAD_BEEF, "R1");
    // R2
    longOp(MULU, NEG1, NEG1, "R2");
    longOp(MULU, MINV, 32'd2, "R2");
    longOp(MULU, 32'd12345, 32'd6789, "R2");
    // R3
    longOp(DIVS, -32'sd7, 32'd2, "R3");
    longOp(DIVS, 32'd7, -32'sd2, "R3");
    longOp(DIVS, MINV, NEG1, "R3");
    longOp(DIVS, NEG1, MINV, "R3");
    longOp(DIVS, 32'd100, 32'd7, "R3");
    longOp(DIVS, 32'd0, NEG1, "R3");
    // R4
    longOp(DIVU, NEG1, 32'd1, "R4");
    longOp(DIVU, 32'd7, NEG1, "R4");
    longOp(DIVU, MINV, 32'd3, "R4");

    // R8: a new divide held behind a running one
    model(DIVS, 32'd1000, 32'd3);
    issue(DIVS, 32'd1000, 32'd3);
    @(negedge clk);
    reqOp = DIVU; reqA = 32'hF000_0001; reqB = 32'd10;
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    check(cnt == XLEN, "R8", "first run length", 64'(cnt), 64'(XLEN));
    @(posedge clk); @(negedge clk);
    check(busy == 1'b1, "R8", "held divide started", {63'b0, busy}, 64'h1);
    reqValid = 1'b0;
    model(DIVU, 32'hF000_0001, 32'd10);
    while (busy) @(negedge clk);
    readBoth("R8");

    // R9: array multiplier variant
    model(MULS, -32'sd5, 32'd9);
    @(negedge clk);
    fValid = 1'b1; fOp = MULS; fA = -32'sd5; fB = 32'd9;
    @(posedge clk); @(negedge clk);
    check(!fBusy && fReady, "R9", "no busy for array multiply", {62'b0, fBusy, fReady}, 64'h1);
    fOp = GETLO;
    @(posedge clk); @(negedge clk);
    check(fRdValid && fRdData == mLo, "R9", "array LO", {31'b0, fRdValid, fRdData}, {32'h1, mLo});
    fOp = GETHI;
    @(posedge clk); @(negedge clk);
    check(fRdValid && fRdData == mHi, "R9", "array HI", {31'b0, fRdValid, fRdData}, {32'h1, mHi});
    fValid = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule